// File: doc/BRIEF.md
# Four-Phase Fetch and Execute Sequencer

This block paces a small processor core. It turns the input clock into four phase strobes that take turns, one per clock. One full turn of the four phases is one instruction cycle. Within that frame the block runs a two-stage pipeline. While one instruction word sits in the instruction register and executes, the next word is fetched from program memory at the address the program counter holds. The fetch address is the program counter itself. Program memory is external and synchronous, with a read latency of one clock.

The execute unit sits outside the block. It sees the instruction register, the execute-valid flag and two enables: an operand-read enable in the second phase and a destination-write enable in the fourth phase. To change the flow of the program, it raises a branch request with a target address. The request is taken at the end of the fourth phase of a valid cycle. The prefetched word then enters the register in a squashed cycle, and the target word is fetched during that cycle. Reset works the same way: the first cycle after reset is squashed, because nothing has been fetched yet.

Top module: `quad_fetch_seq`

## Requirements
- R1: `phase` is one-hot, with bit 0 as phase one and bit 3 as phase four. It steps 1→2→3→4→1 on every clock. One full turn is one instruction cycle.
- R2: While `rst` is high at a clock edge (synchronous, active high), the block sets `phase` to phase one and clears `pc` and `ir`. The cycle that follows reset is squashed: `execValid`, `opRdEn` and `dstWrEn` stay low for all four of its phases.
- R3: `pc` changes only on the edge from phase four to phase one. When no branch is taken on that edge, `pc` rises by one, and 1023 wraps to 0.
- R4: On the edge into phase four, the block latches `imemData` (a synchronous read of address `pc` with one clock of latency). On the next edge into phase one, that word enters `ir`. `ir` holds its value for the whole cycle.
- R5: `opRdEn` is high exactly in phase two of a valid cycle. `dstWrEn` is high exactly in phase four of a valid cycle.
- R6: When `branchReq` is high on the edge from phase four to phase one of a valid cycle, `pc` loads `branchTarget` in place of the increment. The cycle that starts then is squashed. The next valid cycle executes the word stored at the target.
- R7: `branchReq` has no effect on any other edge, and none in a squashed cycle.
- R8: `execValid` changes only on the edge into phase one. It stays constant over the four phases of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, one phase per period |
| rst | input | 1 | Synchronous reset, active high |
| imemData | input | 12 | Program memory read data for address `pc`, one clock after the address |
| branchReq | input | 1 | Request to redirect the program counter, taken at the end of phase four |
| branchTarget | input | 10 | Address to load on a taken branch |
| phase | output | 4 | One-hot phase strobes, bit 0 = phase one |
| pc | output | 10 | Program counter and fetch address |
| ir | output | 12 | Instruction register |
| execValid | output | 1 | Current cycle executes a real instruction |
| opRdEn | output | 1 | Operand read enable (phase two of a valid cycle) |
| dstWrEn | output | 1 | Destination write enable (phase four of a valid cycle) |

## Verification
The phase moves on every clock. `pc`, `ir` and `execValid` move only on the edge into phase one, and the fetch latch fills one edge earlier, on the edge into phase four. A branch raised during phase four shows up as the new `pc` and a low `execValid` just one clock later. The target's word reaches `ir` a full instruction cycle (four clocks) after that. The bench's reference model advances on the same edges as the design and is compared on the falling edge, so each result is checked in the first half-clock where it is due. The bench also drives requests in the wrong phases and during squashed cycles, and the model has to agree that they do nothing.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  localparam int NumPhases = 4;

  typedef struct packed {
    logic capture;   // edge into phase four: latch fetched word
    logic cycleEnd;  // edge into phase one: advance pc and ir
    logic redirect;  // taken branch on this cycleEnd
    logic opRd;      // operand read strobe
    logic dstWr;     // destination write strobe
  } seqStrobes_t;

endpackage

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 branchReq,
  output logic [NumPhases-1:0] phase,
  output logic                 execValid,
  output seqStrobes_t          strb
);

  localparam int LastPhase = NumPhases - 1;

  logic [NumPhases-1:0] phaseReg;
  logic                 validReg;
  logic                 takeBranch;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseReg <= {{(NumPhases-1){1'b0}}, 1'b1};
    end else begin
      phaseReg <= {phaseReg[NumPhases-2:0], phaseReg[LastPhase]};
    end
  end

  assign takeBranch = phaseReg[LastPhase] & validReg & branchReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      validReg <= 1'b0;
    end else if (phaseReg[LastPhase]) begin
      validReg <= ~takeBranch;
    end
  end

  always_comb begin
    strb.capture  = phaseReg[LastPhase-1];
    strb.cycleEnd = phaseReg[LastPhase];
    strb.redirect = takeBranch;
    strb.opRd     = validReg & phaseReg[1];
    strb.dstWr    = validReg & phaseReg[LastPhase];
  end

  assign phase     = phaseReg;
  assign execValid = validReg;

endmodule

// File: rtl/qseq_dpath.sv
module qseq_dpath
  import qseq_pkg::*;
#(
  parameter int InstrWidth = 12,
  parameter int MemDepth   = 1024,
  localparam int AddrWidth = $clog2(MemDepth)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobes_t           strb,
  input  logic [InstrWidth-1:0] imemData,
  input  logic [AddrWidth-1:0]  branchTarget,
  output logic [AddrWidth-1:0]  pc,
  output logic [InstrWidth-1:0] ir
);

  logic [AddrWidth-1:0]  pcReg;
  logic [InstrWidth-1:0] fetchLatch;
  logic [InstrWidth-1:0] irReg;
  logic [AddrWidth-1:0]  pcNext;

  always_comb begin
    if (strb.redirect) pcNext = branchTarget;
    else               pcNext = pcReg + AddrWidth'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchLatch <= '0;
    end else if (strb.capture) begin
      fetchLatch <= imemData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= '0;
      irReg <= '0;
    end else if (strb.cycleEnd) begin
      pcReg <= pcNext;
      irReg <= fetchLatch;
    end
  end

  assign pc = pcReg;
  assign ir = irReg;

endmodule

// File: rtl/quad_fetch_seq.sv
module quad_fetch_seq
  import qseq_pkg::*;
#(
  parameter int InstrWidth = 12,
  parameter int MemDepth   = 1024,
  localparam int AddrWidth = $clog2(MemDepth)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [InstrWidth-1:0] imemData,
  input  logic                  branchReq,
  input  logic [AddrWidth-1:0]  branchTarget,
  output logic [NumPhases-1:0]  phase,
  output logic [AddrWidth-1:0]  pc,
  output logic [InstrWidth-1:0] ir,
  output logic                  execValid,
  output logic                  opRdEn,
  output logic                  dstWrEn
);

  seqStrobes_t strb;

  qseq_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .branchReq (branchReq),
    .phase     (phase),
    .execValid (execValid),
    .strb      (strb)
  );

  qseq_dpath #(
    .InstrWidth (InstrWidth),
    .MemDepth   (MemDepth)
  ) uDpath (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .imemData     (imemData),
    .branchTarget (branchTarget),
    .pc           (pc),
    .ir           (ir)
  );

  assign opRdEn  = strb.opRd;
  assign dstWrEn = strb.dstWr;

endmodule

// File: rtl/quad_fetch_seq_chk.sv
module quad_fetch_seq_chk #(
  parameter int InstrWidth = 12,
  parameter int AddrWidth  = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  branchReq,
  input logic [AddrWidth-1:0]  branchTarget,
  input logic [3:0]            phase,
  input logic [AddrWidth-1:0]  pc,
  input logic [InstrWidth-1:0] ir,
  input logic                  execValid,
  input logic                  opRdEn,
  input logic                  dstWrEn
);

  a_r1_one_phase: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);

  a_r1_wraps_to_first: assert property (@(posedge clk) disable iff (rst)
    phase[3] |=> phase[0]);

  a_r3_pc_held: assert property (@(posedge clk) disable iff (rst)
    !phase[3] |=> $stable(pc));

  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && !(execValid && branchReq)) |=> pc == AddrWidth'($past(pc) + 1'b1));

  a_r4_ir_held: assert property (@(posedge clk) disable iff (rst)
    !phase[3] |=> $stable(ir));

  a_r6_redirect: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && execValid && branchReq) |=> (pc == $past(branchTarget)) && !execValid);

  a_r8_valid_held: assert property (@(posedge clk) disable iff (rst)
    !phase[3] |=> $stable(execValid));

  a_r5_no_enable_when_squashed: assert property (@(posedge clk) disable iff (rst)
    !execValid |-> !opRdEn && !dstWrEn);

endmodule

bind quad_fetch_seq quad_fetch_seq_chk #(
  .InstrWidth (InstrWidth),
  .AddrWidth  (AddrWidth)
) uChk (
  .clk          (clk),
  .rst          (rst),
  .branchReq    (branchReq),
  .branchTarget (branchTarget),
  .phase        (phase),
  .pc           (pc),
  .ir           (ir),
  .execValid    (execValid),
  .opRdEn       (opRdEn),
  .dstWrEn      (dstWrEn)
);

// File: tb/quad_fetch_seq_test.sv
module quad_fetch_seq_test;

  localparam int ClkPeriod = 10;
  localparam int RunClocks = 1200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] imemData;
  logic        branchReq = 1'b0;
  logic [9:0]  branchTarget = '0;
  logic [3:0]  phase;
  logic [9:0]  pc;
  logic [11:0] ir;
  logic        execValid, opRdEn, dstWrEn;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int mPhase = 0, mPc = 0, mIr = 0, mLatch = 0, icount = 0;
  bit mValid = 0, sawWrap = 0, sawFlushIgnore = 0;

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic [11:0] romWord(input int a);
    return 12'((a * 37 + 5) ^ (a >> 3));
  endfunction

  logic [11:0] romQ = '0;
  always @(posedge clk) romQ <= romWord(int'(pc));
  assign imemData = romQ;

  quad_fetch_seq uut (
    .clk(clk), .rst(rst), .imemData(imemData), .branchReq(branchReq),
    .branchTarget(branchTarget), .phase(phase), .pc(pc), .ir(ir),
    .execValid(execValid), .opRdEn(opRdEn), .dstWrEn(dstWrEn)
  );

  // reference model: advances on the same edges the requirements name
  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mPc = 0; mIr = 0; mLatch = 0; mValid = 0;
    end else begin
      if (mPhase == 2) mLatch = int'(romWord(mPc));          // R4 capture
      if (mPhase == 3) begin
        bit take;
        take = mValid && branchReq;                           // R6 / R7
        if (branchReq && !mValid) sawFlushIgnore = 1;
        mIr = mLatch;
        if (take) mPc = int'(branchTarget);
        else begin
          if (mPc == 1023) sawWrap = 1;
          mPc = (mPc + 1) % 1024;                              // R3
        end
        mValid = !take;
        icount++;
      end
      mPhase = (mPhase + 1) % 4;                               // R1
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(phase == 4'(1 << mPhase), "R1", "phase", int'(phase), 1 << mPhase);
    chk(int'(pc) == mPc, "R3", "pc", int'(pc), mPc);
    chk(int'(ir) == mIr, "R4", "ir", int'(ir), mIr);
    chk(execValid == mValid, "R8", "execValid", int'(execValid), int'(mValid));
    chk(opRdEn == (mValid && mPhase == 1), "R5", "opRdEn",
        int'(opRdEn), int'(mValid && mPhase == 1));
    chk(dstWrEn == (mValid && mPhase == 3), "R5", "dstWrEn",
        int'(dstWrEn), int'(mValid && mPhase == 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: state held by reset
    chk(phase == 4'b0001, "R2", "reset phase", int'(phase), 1);
    chk(pc == 10'd0, "R2", "reset pc", int'(pc), 0);
    chk(ir == 12'd0, "R2", "reset ir", int'(ir), 0);
    chk(!execValid && !opRdEn && !dstWrEn, "R2", "reset enables",
        int'({execValid, opRdEn, dstWrEn}), 0);
    rst = 1'b0;
    for (int c = 0; c < RunClocks; c++) begin
      @(negedge clk);
      compareAll();
      if (icount == 0)  // R2: squashed first cycle
        chk(!execValid && !opRdEn && !dstWrEn, "R2", "first cycle squashed",
            int'({execValid, opRdEn, dstWrEn}), 0);
      // drive stimulus for the next edge
      branchReq    = 1'b0;
      branchTarget = 10'(c * 13);
      if (mPhase == 3) begin
        if (icount == 20) begin
          branchReq = 1'b1; branchTarget = 10'd1022;            // R3 wrap path
        end else if (icount % 7 == 3 || icount % 7 == 4) begin
          branchReq = 1'b1; branchTarget = 10'((icount * 97) % 1024); // R6, R7 flushed
        end
      end else if (icount % 5 == 0) begin
        branchReq = 1'b1; branchTarget = 10'd777;               // R7 wrong phase
      end
    end
    chk(sawWrap, "R3", "wrap 1023 to 0 exercised", int'(sawWrap), 1);
    chk(sawFlushIgnore, "R7", "request in squashed cycle exercised",
        int'(sawFlushIgnore), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(ClkPeriod * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule